// File: doc/BRIEF.md
# Pattern Address Counter with Dual Reset

This block produces the read address for a two-bank pattern memory. An 8-bit count advances by one on each advance strobe from the upstream clock selector. A ninth address bit, taken from a control register, picks one of the two 256-entry banks. Software sees two registers. The control register starts and stops counting, picks the reset sources, selects the bank and turns on automatic failover. The count register can be read at any time. A write to it loads the value on the next advance.

The count can return to zero from two sources. The first is a crossing pulse from the machine. It is remembered until the next advance, and that advance yields 0 in place of the next count. The second is a comparison against an 8-bit terminal count taken from switches. The advance that finds the count equal to that value returns it to 0. In automatic mode the crossing pulse acts as the reset. If 512 advances pass with no crossing pulse, the block falls back to terminal-count reset and raises a status bit. The next crossing pulse returns it to crossing mode.

Control register bits (index from 0):

| Bit | Meaning |
|-----|---------|
| 0 | Run |
| 1 | Terminal-count reset off |
| 2 | Crossing reset on |
| 3 | Stored only |
| 4 | Bank |
| 5 | Automatic failover |
| 6, 7 | Stored only |

Top module: `pattern_addr_ctr`

## Requirements
- R1: After reset, `count_o`, `aux_o`, `mem_addr_o` and `fallback_o` are all zero.
- R2: With control bit 0 (run) at 1, each advance strobe raises the count by one. With run at 0, an advance leaves the count unchanged. Without an advance the count never changes.
- R3: When control bit 1 is 0 and an advance finds the count equal to `term_i`, the count becomes 0 and the next advance gives 1. When bit 1 is 1 the comparison has no effect: the count passes `term_i` and wraps from 255 to 0.
- R4: When control bit 2 is 1, a crossing pulse in the same cycle as an advance makes that advance yield 0. So does a pulse in any cycle since the previous advance. The following advance gives 1. When bit 2 is 0, crossing pulses do not affect the count. Every advance discards a remembered pulse, even one made while run is 0.
- R5: When both reset sources apply on the same advance, the result is one clear to 0, and the next advance gives 1.
- R6: `mem_addr_o` is control bit 4 followed by the 8-bit count (bit 8 = bank, bits 7:0 = count).
- R7: A write with `wr_sel_i`=0 stores all 8 data bits in the control register, and they are read back on `aux_o` from the next cycle.
- R8: A write with `wr_sel_i`=1 does not change the count by itself. The next advance loads the written value whether run is 0 or 1, and that advance ignores both reset sources.
- R9: With control bit 5 at 1, crossing pulses reset the count whatever bits 1 and 2 hold. The terminal count has no effect until 512 advances pass with no crossing pulse. The 512th such advance sets `fallback_o`, and from then on terminal-count reset applies. A crossing pulse clears `fallback_o` and restarts the 512-advance window. With bit 5 at 0, `fallback_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adv_i | input | 1 | One-cycle advance strobe from the clock selector |
| cross_i | input | 1 | One-cycle crossing pulse, synchronous to clk |
| term_i | input | 8 | Terminal count from switches |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | 0 = control register, 1 = count register |
| wr_data_i | input | 8 | Write data |
| aux_o | output | 8 | Control register readback |
| count_o | output | 8 | Current count |
| mem_addr_o | output | 9 | Pattern memory address |
| fallback_o | output | 1 | Automatic mode is using terminal-count reset |

## Verification
The assertions assume that `adv_i` and `cross_i` are single-cycle strobes already synchronous to `clk`. They also assume that register writes do not share a cycle with an advance. The bench keeps to this by driving strobes and writes in separate cycles, one cycle at a time, between falling edges. The random phase leaves automatic mode off so that its reference model covers only the fixed reset-source settings. The failover window has its own directed sequence of exactly 511 and then 512 advances.

// File: rtl/pac_pkg.sv
package pac_pkg;
    localparam int CNT_W      = 8;
    localparam int AUX_W      = 8;
    localparam int MISS_LIMIT = 512;

    // control register bit positions
    localparam int AUX_RUN    = 0;
    localparam int AUX_TC_OFF = 1;
    localparam int AUX_XR_EN  = 2;
    localparam int AUX_BANK   = 4;
    localparam int AUX_AUTO   = 5;

    typedef enum logic {SEL_AUX = 1'b0, SEL_CNT = 1'b1} reg_sel_e;
endpackage

// File: rtl/pac_ctrl_regs.sv
module pac_ctrl_regs #(
    parameter int AUX_W = pac_pkg::AUX_W,
    parameter int CNT_W = pac_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic             wr_sel_i,
    input  logic [AUX_W-1:0] wr_data_i,
    input  logic             adv_i,
    output logic [AUX_W-1:0] aux_o,
    output logic             load_pend_o,
    output logic [CNT_W-1:0] load_val_o
);
    typedef struct packed {
        logic [AUX_W-1:0] aux;
        logic [CNT_W-1:0] load_val;
        logic             load_pend;
    } regs_t;

    regs_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (adv_i) st_d.load_pend = 1'b0;
        if (wr_en_i) begin
            if (wr_sel_i == pac_pkg::SEL_AUX) begin
                st_d.aux = wr_data_i;
            end else begin
                st_d.load_val  = wr_data_i[CNT_W-1:0];
                st_d.load_pend = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign aux_o       = st_q.aux;
    assign load_pend_o = st_q.load_pend;
    assign load_val_o  = st_q.load_val;

    assert_aux_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_sel_i == pac_pkg::SEL_AUX) |=> (aux_o == $past(wr_data_i)));

    assert_load_arms_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_sel_i == pac_pkg::SEL_CNT) |=> load_pend_o);
endmodule

// File: rtl/pac_fail_mon.sv
module pac_fail_mon #(
    parameter int LIMIT = pac_pkg::MISS_LIMIT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic auto_i,
    input  logic adv_i,
    input  logic cross_i,
    output logic fallback_o
);
    localparam int MISS_W = $clog2(LIMIT + 1);

    typedef struct packed {
        logic [MISS_W-1:0] miss;
        logic              fb;
    } mon_t;

    mon_t st_q, st_d;
    logic [MISS_W-1:0] miss_inc;

    assign miss_inc = st_q.miss + MISS_W'(1);

    always_comb begin
        st_d = st_q;
        if (!auto_i || cross_i) begin
            st_d.miss = '0;
            st_d.fb   = 1'b0;
        end else if (adv_i && !st_q.fb) begin
            st_d.miss = miss_inc;
            if (miss_inc == MISS_W'(LIMIT)) st_d.fb = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fallback_o = st_q.fb;

    assert_fb_needs_adv_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fallback_o) |-> $past(adv_i && !cross_i && auto_i));

    assert_cross_clears_fb_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cross_i |=> !fallback_o);

    assert_manual_no_fb_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_i |=> !fallback_o);
endmodule

// File: rtl/pac_addr_cnt.sv
module pac_addr_cnt #(
    parameter int CNT_W = pac_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_i,
    input  logic             cross_i,
    input  logic             run_i,
    input  logic             load_pend_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             tc_en_i,
    input  logic             xr_en_i,
    input  logic [CNT_W-1:0] term_i,
    output logic [CNT_W-1:0] cnt_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             xpend;
    } cnt_t;

    cnt_t st_q, st_d;
    logic cross_hit, tc_hit, clr;

    assign cross_hit = xr_en_i && (st_q.xpend || cross_i);
    assign tc_hit    = tc_en_i && (st_q.cnt == term_i);
    assign clr       = cross_hit || tc_hit;

    always_comb begin
        st_d = st_q;
        if (adv_i) begin
            st_d.xpend = 1'b0;
            if (load_pend_i)  st_d.cnt = load_val_i;
            else if (run_i)   st_d.cnt = clr ? '0 : st_q.cnt + CNT_W'(1);
        end else if (cross_i) begin
            st_d.xpend = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

    assert_hold_no_adv_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> $stable(cnt_o));

    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && run_i && !load_pend_i && !xr_en_i && !tc_en_i)
        |=> (cnt_o == $past(cnt_o) + CNT_W'(1)));

    assert_tc_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && run_i && !load_pend_i && tc_en_i && cnt_o == term_i) |=> (cnt_o == '0));

    assert_cross_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && run_i && !load_pend_i && xr_en_i && cross_i) |=> (cnt_o == '0));

    assert_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && load_pend_i) |=> (cnt_o == $past(load_val_i)));
endmodule

// File: rtl/pattern_addr_ctr.sv
module pattern_addr_ctr #(
    parameter int CNT_W = pac_pkg::CNT_W,
    parameter int AUX_W = pac_pkg::AUX_W,
    parameter int LIMIT = pac_pkg::MISS_LIMIT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_i,
    input  logic             cross_i,
    input  logic [CNT_W-1:0] term_i,
    input  logic             wr_en_i,
    input  logic             wr_sel_i,
    input  logic [AUX_W-1:0] wr_data_i,
    output logic [AUX_W-1:0] aux_o,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W:0]   mem_addr_o,
    output logic             fallback_o
);
    import pac_pkg::*;

    logic             load_pend;
    logic [CNT_W-1:0] load_val;
    logic             auto_on, tc_en, xr_en;

    pac_ctrl_regs #(.AUX_W(AUX_W), .CNT_W(CNT_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (wr_en_i),
        .wr_sel_i    (wr_sel_i),
        .wr_data_i   (wr_data_i),
        .adv_i       (adv_i),
        .aux_o       (aux_o),
        .load_pend_o (load_pend),
        .load_val_o  (load_val)
    );

    assign auto_on = aux_o[AUX_AUTO];

    pac_fail_mon #(.LIMIT(LIMIT)) u_mon (
        .clk        (clk),
        .rst_n      (rst_n),
        .auto_i     (auto_on),
        .adv_i      (adv_i),
        .cross_i    (cross_i),
        .fallback_o (fallback_o)
    );

    // reset-source selection: automatic mode overrides the manual bits
    assign xr_en = auto_on ? 1'b1       : aux_o[AUX_XR_EN];
    assign tc_en = auto_on ? fallback_o : !aux_o[AUX_TC_OFF];

    pac_addr_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .adv_i       (adv_i),
        .cross_i     (cross_i),
        .run_i       (aux_o[AUX_RUN]),
        .load_pend_i (load_pend),
        .load_val_i  (load_val),
        .tc_en_i     (tc_en),
        .xr_en_i     (xr_en),
        .term_i      (term_i),
        .cnt_o       (count_o)
    );

    assign mem_addr_o = {aux_o[AUX_BANK], count_o};

    assert_both_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && aux_o[AUX_RUN] && !load_pend && xr_en && cross_i && tc_en && count_o == term_i)
        |=> (count_o == '0));
endmodule

// File: tb/pattern_addr_ctr_tb.sv
`timescale 1ns/1ps
module pattern_addr_ctr_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       adv_i = 1'b0, cross_i = 1'b0;
    logic [7:0] term_i = 8'd255;
    logic       wr_en_i = 1'b0, wr_sel_i = 1'b0;
    logic [7:0] wr_data_i = 8'd0;
    logic [7:0] aux_o, count_o;
    logic [8:0] mem_addr_o;
    logic       fallback_o;

    int checks = 0, failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pattern_addr_ctr dut_i (
        .clk(clk), .rst_n(rst_n), .adv_i(adv_i), .cross_i(cross_i), .term_i(term_i),
        .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
        .aux_o(aux_o), .count_o(count_o), .mem_addr_o(mem_addr_o), .fallback_o(fallback_o)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(bit a, bit x);
        @(negedge clk); adv_i = a; cross_i = x;
        @(negedge clk); adv_i = 1'b0; cross_i = 1'b0;
    endtask

    task automatic wr(bit sel, logic [7:0] d);
        @(negedge clk); wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
        @(negedge clk); wr_en_i = 1'b0;
    endtask

    // reference model of the count, built from R2, R3, R4, R5, R8
    function automatic logic [7:0] next_cnt(logic [7:0] c, logic [7:0] aux, logic [7:0] tc,
                                            bit xhit, bit ldp, logic [7:0] ldv);
        if (ldp) return ldv;
        if (!aux[0]) return c;
        if ((aux[2] && xhit) || (!aux[1] && c == tc)) return 8'd0;
        return c + 8'd1;
    endfunction

    initial begin
        #500us;
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] ec, eaux, eldv, a, v;
        bit exp_xp, eldp;
        int lim;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 count", count_o, 0);
        chk("R1 aux", aux_o, 0);
        chk("R1 addr", mem_addr_o, 0);
        chk("R1 fallback", fallback_o, 0);

        // R7 readback
        wr(0, 8'hC9);
        chk("R7 aux readback", aux_o, 8'hC9);
        wr(0, 8'h03);              // run, tc off
        step(1, 0); step(1, 0); step(1, 0);
        chk("R2 increments", count_o, 3);
        step(0, 0);
        chk("R2 no advance holds", count_o, 3);
        wr(0, 8'h00);
        step(1, 0);
        chk("R2 stopped holds", count_o, 3);

        // R8 load while stopped
        wr(1, 8'd200);
        chk("R8 write alone no change", count_o, 3);
        step(1, 0);
        chk("R8 loaded on advance", count_o, 200);

        // R3 terminal count
        term_i = 8'd203;
        wr(0, 8'h01);
        step(1, 0); step(1, 0); step(1, 0);
        chk("R3 at term", count_o, 203);
        step(1, 0);
        chk("R3 clear after term", count_o, 0);
        step(1, 0);
        chk("R3 continues to 1", count_o, 1);
        wr(0, 8'h03);
        term_i = 8'd10;
        wr(1, 8'd9); step(1, 0); step(1, 0); step(1, 0);
        chk("R3 disabled passes term", count_o, 11);
        wr(1, 8'd254); step(1, 0); step(1, 0);
        chk("R3 at 255", count_o, 255);
        step(1, 0);
        chk("R3 natural wrap", count_o, 0);

        // R4 crossing reset
        term_i = 8'd255;
        wr(0, 8'h05);
        wr(1, 8'd50); step(1, 0);
        step(0, 1);
        chk("R4 pulse alone no change", count_o, 50);
        step(1, 0);
        chk("R4 remembered pulse clears", count_o, 0);
        step(1, 0);
        chk("R4 continues to 1", count_o, 1);
        step(1, 1);
        chk("R4 coincident pulse clears", count_o, 0);
        wr(0, 8'h03);
        step(1, 0); step(1, 1);
        chk("R4 disabled ignores pulse", count_o, 2);
        wr(0, 8'h04);
        step(0, 1); step(1, 0);
        wr(0, 8'h05);
        step(1, 0);
        chk("R4 pulse dropped while stopped", count_o, 3);

        // R5 both sources together
        term_i = 8'd5;
        wr(1, 8'd5); step(1, 0);
        step(1, 1);
        chk("R5 single clear", count_o, 0);
        step(1, 0);
        chk("R5 continues to 1", count_o, 1);

        // R6 bank bit
        wr(0, 8'h15);
        chk("R6 bank address", mem_addr_o, 9'h100 | 9'(count_o));
        wr(0, 8'h05);
        chk("R6 bank low address", mem_addr_o, 9'(count_o));

        // R9 automatic failover
        term_i = 8'd10;
        wr(0, 8'h23);
        step(1, 1);
        chk("R9 crossing resets in auto", count_o, 0);
        for (int i = 0; i < 511; i++) step(1, 0);
        chk("R9 no fallback at 511", fallback_o, 0);
        chk("R9 term ignored before fallback", count_o, 511 % 256);
        step(1, 0);
        chk("R9 fallback at 512", fallback_o, 1);
        lim = 0;
        while (count_o != 8'd10 && lim < 300) begin step(1, 0); lim++; end
        step(1, 0);
        chk("R9 term reset after fallback", count_o, 0);
        step(0, 1);
        chk("R9 crossing clears fallback", fallback_o, 0);
        step(1, 0);
        chk("R9 remembered crossing clears count", count_o, 0);
        wr(0, 8'h01);
        chk("R9 manual mode fallback low", fallback_o, 0);

        // random phase, automatic mode off
        eaux = 8'h05;
        wr(0, eaux);
        step(1, 0);
        ec = count_o; exp_xp = 0; eldp = 0; eldv = 0;
        for (int n = 0; n < 4000; n++) begin
            int r;
            bit a_b, x_b;
            r = int'($urandom % 100);
            if (r < 5) begin
                a = 8'($urandom) & 8'hDF;
                wr(0, a); eaux = a;
            end else if (r < 8) begin
                v = 8'($urandom);
                wr(1, v); eldp = 1; eldv = v;
            end else begin
                if (r < 10) term_i = 8'($urandom);
                a_b = ($urandom % 100) < 60;
                x_b = ($urandom % 100) < 10;
                step(a_b, x_b);
                if (a_b) begin
                    ec = next_cnt(ec, eaux, term_i, exp_xp || x_b, eldp, eldv);
                    eldp = 0; exp_xp = 0;
                end else if (x_b) begin
                    exp_xp = 1;
                end
            end
            chk("R2 R3 R4 R5 R8 random count", count_o, ec);
            chk("R6 random address", mem_addr_o, {eaux[4], ec});
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule